// File: doc/BRIEF.md
# USB Root Hub Port Status Tracker

This block holds the status and change bits of every downstream port of a small USB host-controller root hub, together with the controller's functional-state field. It turns attach, detach and remote-wakeup event pulses into port status updates, and it sends single-cycle set pulses to the controller's interrupt register. Software clears change bits by writing ones. Software also writes the functional state. A synchronous controller reset returns every port and the functional state to zero.

Each port runs a four-state machine: PS_DETACHED, PS_ATTACHED, PS_ENABLED and PS_SUSPENDED. The connect, enable and suspend bits are decoded from that state, and three change flags sit beside it. The events are checked in a fixed priority order:

1. Controller reset takes any port state to PS_DETACHED.
2. A detach takes any connected port state to PS_DETACHED.
3. An attach takes PS_DETACHED to PS_ATTACHED.
4. A wakeup takes PS_SUSPENDED to PS_ENABLED.
5. A high enable qualifier takes PS_ATTACHED to PS_ENABLED.
6. A low enable qualifier takes PS_ENABLED or PS_SUSPENDED to PS_ATTACHED.
7. A suspend request takes PS_ENABLED to PS_SUSPENDED.

The controller machine uses the states FS_RESET, FS_RESUME, FS_OPER and FS_SUSPEND. A software write moves it to any state. A wakeup on any port takes FS_SUSPEND to FS_RESUME, and a controller reset takes any state to FS_RESET. The wakeup transition has priority over a software write in the same cycle.

Top module: `usb_rh_port_tracker`

## Requirements
- R1: An attach pulse on a port sets its connect bit (bit 0) and its connect-change bit (bit 16) on the next clock. If a detach pulse arrives on the same port in the same cycle, the detach wins.
- R2: A detach pulse clears the connect bit only if it was set. When it does, it also sets the connect-change bit and clears the enable (bit 1) and suspend (bit 2) bits. The enable-change bit (bit 17) is also set if the port was enabled. A detach on an unconnected port leaves the port word unchanged.
- R3: Interrupt bit 6 (port status change) pulses for one cycle after an attach, detach or wakeup only when that event actually altered the port's status word.
- R4: A wakeup on a port whose suspend bit is set clears the suspend bit and sets the suspend-change bit (bit 18). While the controller is not in suspend, it also requests interrupt bit 6. A wakeup on a port that is not suspended changes nothing on that port.
- R5: A wakeup on any port while the functional state is 2'b11 (suspend) moves the state to 2'b01 (resume). It then pulses interrupt bit 3 (resume detected) and requests no bit 6 for that wakeup. This holds even when the port itself is not suspended.
- R6: A controller reset pulse clears every port status word to zero, sets the functional state to 2'b00 (reset) and overrides all other events in that cycle.
- R7: Every detach pulse gives a one-cycle cancel pulse for that port on the next clock, whatever the port's state.
- R8: A change-clear write carries a three-bit mask: bit 0 for connect-change, bit 1 for enable-change, bit 2 for suspend-change. It clears exactly the change bits selected with a one on the addressed port, and a zero mask bit leaves that flag unchanged. A hardware set in the same cycle wins over the clear.
- R9: A connected port becomes enabled one clock after its enable qualifier is high. If the qualifier drops while the port is enabled or suspended, the enable bit clears and the enable-change bit sets.
- R10: A suspend request on an enabled port sets its suspend bit on the next clock.
- R11: A software state write loads the functional state with encoding 00 reset, 01 resume, 10 operational, 11 suspend.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hc_reset_i | input | 1 | Synchronous controller reset pulse |
| attach_i | input | NPORTS | Per-port device attach pulse |
| detach_i | input | NPORTS | Per-port device detach pulse |
| wakeup_i | input | NPORTS | Per-port remote-wakeup pulse |
| port_en_i | input | NPORTS | Per-port enable qualifier (level) |
| susp_req_i | input | NPORTS | Per-port suspend request pulse |
| chg_clr_i | input | 1 | Change-clear write strobe |
| chg_clr_port_i | input | PW | Port addressed by the change-clear write |
| chg_clr_mask_i | input | 3 | Change bits to clear: bit0 connect, bit1 enable, bit2 suspend |
| fs_wr_i | input | 1 | Functional-state write strobe |
| fs_wr_val_i | input | 2 | Functional-state value to write |
| port_status_o | output | NPORTS*32 | Port status words, port 0 in the low 32 bits |
| fs_o | output | 2 | Current functional state |
| int_set_o | output | IRQ_W | Interrupt set pulses: bit 3 resume detected, bit 6 port status change |
| cancel_o | output | NPORTS | Per-port in-flight transfer cancel pulse |

## Verification
Every result of this block is registered once, so a status word, the functional state, an interrupt pulse and a cancel pulse are all due one rising edge after the input that causes them. The bench drives each stimulus on a falling edge and tags each expected value with the following cycle number. Its monitor compares one nanosecond after that rising edge, when the registers have settled and before the next inputs change. Interrupt and cancel pulses are checked to drop again in the cycle after they fire, which shows they last a single cycle.

// File: rtl/rh_pkg.sv
package rh_pkg;
    localparam int SW     = 32;
    localparam int B_CCS  = 0;
    localparam int B_PES  = 1;
    localparam int B_PSS  = 2;
    localparam int B_CSC  = 16;
    localparam int B_PESC = 17;
    localparam int B_PSSC = 18;
    localparam int B_RD   = 3;
    localparam int B_RHSC = 6;

    typedef enum logic [1:0] {
        FS_RESET   = 2'b00,
        FS_RESUME  = 2'b01,
        FS_OPER    = 2'b10,
        FS_SUSPEND = 2'b11
    } fs_e;

    typedef enum logic [1:0] {
        PS_DETACHED  = 2'b00,
        PS_ATTACHED  = 2'b01,
        PS_ENABLED   = 2'b10,
        PS_SUSPENDED = 2'b11
    } ps_e;
endpackage

// File: rtl/rh_port_slice.sv
module rh_port_slice
    import rh_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hc_reset_i,
    input  logic          attach_i,
    input  logic          detach_i,
    input  logic          wakeup_i,
    input  logic          en_i,
    input  logic          susp_req_i,
    input  logic          clr_i,
    input  logic [2:0]    clr_mask_i,
    output logic [SW-1:0] status_o,
    output logic          ad_chg_o,
    output logic          wk_chg_o,
    output logic          cancel_o
);
    ps_e  state_q, state_d;
    logic csc_q, pesc_q, pssc_q;
    logic set_csc, set_pesc, set_pssc;

    // next-state process
    always_comb begin
        state_d  = state_q;
        set_csc  = 1'b0;
        set_pesc = 1'b0;
        set_pssc = 1'b0;
        ad_chg_o = 1'b0;
        wk_chg_o = 1'b0;
        if (hc_reset_i) begin
            state_d = PS_DETACHED;
        end else if (detach_i) begin
            if (state_q != PS_DETACHED) begin
                state_d  = PS_DETACHED;
                set_csc  = 1'b1;
                ad_chg_o = 1'b1;
                set_pesc = (state_q == PS_ENABLED) || (state_q == PS_SUSPENDED);
            end
        end else if (attach_i) begin
            set_csc  = 1'b1;
            ad_chg_o = (state_q == PS_DETACHED) || !csc_q;
            if (state_q == PS_DETACHED) state_d = PS_ATTACHED;
        end else begin
            unique case (state_q)
                PS_DETACHED: state_d = PS_DETACHED;
                PS_ATTACHED: if (en_i) state_d = PS_ENABLED;
                PS_ENABLED: begin
                    if (!en_i) begin
                        state_d  = PS_ATTACHED;
                        set_pesc = 1'b1;
                    end else if (susp_req_i) begin
                        state_d = PS_SUSPENDED;
                    end
                end
                PS_SUSPENDED: begin
                    if (wakeup_i) begin
                        state_d  = PS_ENABLED;
                        set_pssc = 1'b1;
                        wk_chg_o = 1'b1;
                    end else if (!en_i) begin
                        state_d  = PS_ATTACHED;
                        set_pesc = 1'b1;
                    end
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= PS_DETACHED;
            csc_q    <= 1'b0;
            pesc_q   <= 1'b0;
            pssc_q   <= 1'b0;
            cancel_o <= 1'b0;
        end else begin
            state_q  <= state_d;
            csc_q    <= !hc_reset_i && (set_csc  || (csc_q  && !(clr_i && clr_mask_i[0])));
            pesc_q   <= !hc_reset_i && (set_pesc || (pesc_q && !(clr_i && clr_mask_i[1])));
            pssc_q   <= !hc_reset_i && (set_pssc || (pssc_q && !(clr_i && clr_mask_i[2])));
            cancel_o <= detach_i;
        end
    end

    // output process
    always_comb begin
        status_o         = '0;
        status_o[B_CCS]  = (state_q != PS_DETACHED);
        status_o[B_PES]  = (state_q == PS_ENABLED) || (state_q == PS_SUSPENDED);
        status_o[B_PSS]  = (state_q == PS_SUSPENDED);
        status_o[B_CSC]  = csc_q;
        status_o[B_PESC] = pesc_q;
        status_o[B_PSSC] = pssc_q;
    end

    AST_ATTACH_CONNECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (attach_i && !detach_i && !hc_reset_i) |=> (status_o[B_CCS] && status_o[B_CSC])); // R1
    AST_DETACH_DISCONNECTS: assert property (@(posedge clk) disable iff (!rst_n)
        (detach_i && !hc_reset_i) |=> !status_o[B_CCS]); // R2
    AST_WAKE_RESUMES_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        (wakeup_i && state_q == PS_SUSPENDED && !attach_i && !detach_i && !hc_reset_i)
        |=> (!status_o[B_PSS] && status_o[B_PSSC])); // R4
    AST_RESET_CLEARS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        hc_reset_i |=> (status_o == '0)); // R6
    AST_DETACH_CANCELS: assert property (@(posedge clk) disable iff (!rst_n)
        detach_i |=> cancel_o); // R7
    AST_CLEAR_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && clr_mask_i[0] && !attach_i && !detach_i && !hc_reset_i) |=> !status_o[B_CSC]); // R8
    AST_CLEAR_ZERO_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !clr_mask_i[0] && status_o[B_CSC] && !hc_reset_i) |=> status_o[B_CSC]); // R8
endmodule

// File: rtl/rh_hc_fsm.sv
module rh_hc_fsm
    import rh_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hc_reset_i,
    input  logic       any_wake_i,
    input  logic       fs_wr_i,
    input  logic [1:0] fs_wr_val_i,
    output logic [1:0] fs_o,
    output logic       resume_hit_o
);
    fs_e fs_q, fs_d;

    // next-state process
    always_comb begin
        fs_d = fs_q;
        if (hc_reset_i) begin
            fs_d = FS_RESET;
        end else begin
            unique case (fs_q)
                FS_SUSPEND: begin
                    if (any_wake_i) fs_d = FS_RESUME;
                    else if (fs_wr_i) fs_d = fs_e'(fs_wr_val_i);
                end
                FS_RESET, FS_RESUME, FS_OPER: begin
                    if (fs_wr_i) fs_d = fs_e'(fs_wr_val_i);
                end
            endcase
        end
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fs_q <= FS_RESET;
        else        fs_q <= fs_d;
    end

    // output process
    always_comb begin
        fs_o         = fs_q;
        resume_hit_o = any_wake_i && !hc_reset_i && (fs_q == FS_SUSPEND);
    end

    AST_SUSPEND_TO_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        resume_hit_o |=> (fs_o == FS_RESUME)); // R5
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        hc_reset_i |=> (fs_o == FS_RESET)); // R6
    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (fs_wr_i && !hc_reset_i && !(any_wake_i && fs_o == FS_SUSPEND)) |=> (fs_o == $past(fs_wr_val_i))); // R11
endmodule

// File: rtl/usb_rh_port_tracker.sv
module usb_rh_port_tracker
    import rh_pkg::*;
#(
    parameter int NPORTS = 3,
    parameter int IRQ_W  = 8,
    localparam int PW    = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 hc_reset_i,
    input  logic [NPORTS-1:0]    attach_i,
    input  logic [NPORTS-1:0]    detach_i,
    input  logic [NPORTS-1:0]    wakeup_i,
    input  logic [NPORTS-1:0]    port_en_i,
    input  logic [NPORTS-1:0]    susp_req_i,
    input  logic                 chg_clr_i,
    input  logic [PW-1:0]        chg_clr_port_i,
    input  logic [2:0]           chg_clr_mask_i,
    input  logic                 fs_wr_i,
    input  logic [1:0]           fs_wr_val_i,
    output logic [NPORTS*SW-1:0] port_status_o,
    output logic [1:0]           fs_o,
    output logic [IRQ_W-1:0]     int_set_o,
    output logic [NPORTS-1:0]    cancel_o
);
    logic [NPORTS-1:0] ad_chg, wk_chg;
    logic              resume_hit;
    logic [IRQ_W-1:0]  int_d;

    for (genvar i = 0; i < NPORTS; i++) begin : g_port
        rh_port_slice u_slice (
            .clk        (clk),
            .rst_n      (rst_n),
            .hc_reset_i (hc_reset_i),
            .attach_i   (attach_i[i]),
            .detach_i   (detach_i[i]),
            .wakeup_i   (wakeup_i[i]),
            .en_i       (port_en_i[i]),
            .susp_req_i (susp_req_i[i]),
            .clr_i      (chg_clr_i && (chg_clr_port_i == PW'(i))),
            .clr_mask_i (chg_clr_mask_i),
            .status_o   (port_status_o[i*SW +: SW]),
            .ad_chg_o   (ad_chg[i]),
            .wk_chg_o   (wk_chg[i]),
            .cancel_o   (cancel_o[i])
        );
    end

    rh_hc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .hc_reset_i   (hc_reset_i),
        .any_wake_i   (|wakeup_i),
        .fs_wr_i      (fs_wr_i),
        .fs_wr_val_i  (fs_wr_val_i),
        .fs_o         (fs_o),
        .resume_hit_o (resume_hit)
    );

    always_comb begin
        int_d         = '0;
        int_d[B_RD]   = resume_hit;
        int_d[B_RHSC] = (|ad_chg) || ((|wk_chg) && !resume_hit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) int_set_o <= '0;
        else        int_set_o <= int_d;
    end

    AST_RHSC_ONLY_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int_set_o[B_RHSC] |-> (port_status_o != $past(port_status_o))); // R3
    AST_RD_REPLACES_RHSC: assert property (@(posedge clk) disable iff (!rst_n)
        ((|wakeup_i) && fs_o == 2'b11 && !hc_reset_i && !(|attach_i) && !(|detach_i))
        |=> (int_set_o[B_RD] && !int_set_o[B_RHSC])); // R5
    AST_RESET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        hc_reset_i |=> (int_set_o == '0)); // R6
endmodule

// File: tb/sim_usb_rh_port_tracker.sv
`timescale 1ns/1ps
module sim_usb_rh_port_tracker;
    localparam int NP = 3;

    typedef struct {
        int          cyc;
        int          sel;
        int          port;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hc_reset = 1'b0;
    logic [NP-1:0] attach = '0, detach = '0, wakeup = '0, port_en = '0, susp_req = '0;
    logic          clr_v = 1'b0;
    logic [1:0]    clr_port = '0;
    logic [2:0]    clr_mask = '0;
    logic          fs_wr = 1'b0;
    logic [1:0]    fs_val = '0;
    logic [NP*32-1:0] status;
    logic [1:0]    fs;
    logic [7:0]    int_set;
    logic [NP-1:0] cancel;

    int    cyc = 0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done = 0;
    item_t sbq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    usb_rh_port_tracker u0 (
        .clk(clk), .rst_n(rst_n), .hc_reset_i(hc_reset),
        .attach_i(attach), .detach_i(detach), .wakeup_i(wakeup),
        .port_en_i(port_en), .susp_req_i(susp_req),
        .chg_clr_i(clr_v), .chg_clr_port_i(clr_port), .chg_clr_mask_i(clr_mask),
        .fs_wr_i(fs_wr), .fs_wr_val_i(fs_val),
        .port_status_o(status), .fs_o(fs), .int_set_o(int_set), .cancel_o(cancel)
    );

    // driver side: expected result due after the next rising edge
    task automatic expect_at(int sel, int port, logic [31:0] exp, string req);
        item_t it;
        it.cyc = cyc + 1; it.sel = sel; it.port = port; it.exp = exp; it.req = req;
        sbq.push_back(it);
    endtask

    task automatic nxt();
        @(negedge clk);
        hc_reset = 1'b0; attach = '0; detach = '0; wakeup = '0; susp_req = '0;
        clr_v = 1'b0; clr_mask = '0; fs_wr = 1'b0;
    endtask

    // monitor side
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
                item_t it;
                logic [31:0] act;
                it = sbq.pop_front();
                case (it.sel)
                    0:       act = status[it.port*32 +: 32];
                    1:       act = {30'd0, fs};
                    2:       act = {24'd0, int_set};
                    default: act = {31'd0, cancel[it.port]};
                endcase
                n_cmp++;
                if (it.cyc != cyc || act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s sel=%0d port=%0d actual=%h expected=%h", it.req, it.sel, it.port, act, it.exp);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state (R6)
        expect_at(0, 0, 32'h0, "R6"); expect_at(0, 2, 32'h0, "R6");
        expect_at(1, 0, 32'h0, "R6"); expect_at(2, 0, 32'h0, "R6");
        nxt();
        // attach port 0 (R1, R3)
        attach[0] = 1'b1;
        expect_at(0, 0, 32'h0001_0001, "R1"); expect_at(2, 0, 32'h40, "R3");
        expect_at(3, 0, 32'h0, "R7");
        nxt();
        expect_at(2, 0, 32'h0, "R3");
        nxt();
        // repeat attach with nothing to change: no interrupt (R3)
        attach[0] = 1'b1;
        expect_at(0, 0, 32'h0001_0001, "R1"); expect_at(2, 0, 32'h0, "R3");
        nxt();
        // clear connect change (R8)
        clr_v = 1'b1; clr_port = 2'd0; clr_mask = 3'b001;
        expect_at(0, 0, 32'h0000_0001, "R8");
        nxt();
        // attach on connected port with cleared change flag does alter word (R3)
        attach[0] = 1'b1;
        expect_at(0, 0, 32'h0001_0001, "R1"); expect_at(2, 0, 32'h40, "R3");
        nxt();
        // clear and enable together (R8, R9)
        clr_v = 1'b1; clr_port = 2'd0; clr_mask = 3'b001; port_en[0] = 1'b1;
        expect_at(0, 0, 32'h0000_0003, "R9");
        nxt();
        // suspend request (R10)
        susp_req[0] = 1'b1;
        expect_at(0, 0, 32'h0000_0007, "R10");
        nxt();
        // state write operational (R11)
        fs_wr = 1'b1; fs_val = 2'b10;
        expect_at(1, 0, 32'h2, "R11");
        nxt();
        // wakeup of a suspended port while operational (R4)
        wakeup[0] = 1'b1;
        expect_at(0, 0, 32'h0004_0003, "R4"); expect_at(2, 0, 32'h40, "R4");
        expect_at(1, 0, 32'h2, "R4");
        nxt();
        clr_v = 1'b1; clr_port = 2'd0; clr_mask = 3'b100;
        expect_at(0, 0, 32'h0000_0003, "R8");
        nxt();
        susp_req[0] = 1'b1; fs_wr = 1'b1; fs_val = 2'b11;
        expect_at(0, 0, 32'h0000_0007, "R10"); expect_at(1, 0, 32'h3, "R11");
        nxt();
        // wakeup with the controller suspended (R5)
        wakeup[0] = 1'b1;
        expect_at(0, 0, 32'h0004_0003, "R4"); expect_at(1, 0, 32'h1, "R5");
        expect_at(2, 0, 32'h08, "R5");
        nxt();
        fs_wr = 1'b1; fs_val = 2'b11;
        expect_at(1, 0, 32'h3, "R11"); expect_at(2, 0, 32'h0, "R5");
        nxt();
        // wakeup on an unsuspended port still resumes the controller (R5)
        wakeup[1] = 1'b1;
        expect_at(1, 0, 32'h1, "R5"); expect_at(2, 0, 32'h08, "R5");
        expect_at(0, 1, 32'h0, "R5");
        nxt();
        // wakeup with nothing suspended: no effect (R4)
        wakeup[2] = 1'b1;
        expect_at(2, 0, 32'h0, "R4"); expect_at(1, 0, 32'h1, "R4");
        expect_at(0, 2, 32'h0, "R4");
        nxt();
        // detach an enabled port (R2, R3, R7)
        detach[0] = 1'b1; port_en[0] = 1'b0;
        expect_at(0, 0, 32'h0007_0000, "R2"); expect_at(2, 0, 32'h40, "R3");
        expect_at(3, 0, 32'h1, "R7");
        nxt();
        expect_at(3, 0, 32'h0, "R7");
        nxt();
        // detach an unconnected port: word unchanged, no irq, still cancels (R2, R3, R7)
        detach[0] = 1'b1;
        expect_at(0, 0, 32'h0007_0000, "R2"); expect_at(2, 0, 32'h0, "R3");
        expect_at(3, 0, 32'h1, "R7");
        nxt();
        // attach and detach together: detach wins (R1)
        attach[1] = 1'b1; detach[1] = 1'b1;
        expect_at(0, 1, 32'h0, "R1"); expect_at(3, 1, 32'h1, "R7");
        nxt();
        attach[2] = 1'b1;
        expect_at(0, 2, 32'h0001_0001, "R1"); expect_at(2, 0, 32'h40, "R3");
        nxt();
        // controller reset overrides an attach (R6)
        hc_reset = 1'b1; attach[1] = 1'b1;
        expect_at(0, 0, 32'h0, "R6"); expect_at(0, 1, 32'h0, "R6");
        expect_at(0, 2, 32'h0, "R6"); expect_at(1, 0, 32'h0, "R6");
        expect_at(2, 0, 32'h0, "R6");
        nxt();
        attach[1] = 1'b1;
        expect_at(0, 1, 32'h0001_0001, "R1");
        nxt();
        // zero mask leaves change bits (R8)
        clr_v = 1'b1; clr_port = 2'd1; clr_mask = 3'b000;
        expect_at(0, 1, 32'h0001_0001, "R8");
        nxt();
        // enable qualifier rise and fall (R9)
        attach[2] = 1'b1; port_en[2] = 1'b1;
        expect_at(0, 2, 32'h0001_0001, "R9");
        nxt();
        expect_at(0, 2, 32'h0001_0003, "R9");
        nxt();
        port_en[2] = 1'b0;
        expect_at(0, 2, 32'h0003_0001, "R9");
        nxt();
        // clearing another port's flags does not touch this one (R8)
        clr_v = 1'b1; clr_port = 2'd2; clr_mask = 3'b111;
        expect_at(0, 2, 32'h0000_0001, "R8"); expect_at(0, 1, 32'h0001_0001, "R8");
        nxt();
        repeat (3) nxt();
        if (sbq.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard actual=%0d pending expected=0", sbq.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule